// File: doc/BRIEF.md
# Character-Timed Sync Pulse Generator

This block produces the horizontal and vertical sync pulses of a character-based video timing controller. The counters that decide where a sync pulse starts are outside the block. They signal the start of each pulse with a one-cycle strobe. The block then holds the sync output high for a programmed length. The horizontal pulse length is counted in character-clock enables, and the vertical pulse length in raster-line ticks.

Both lengths come from one packed 8-bit width register. Bits [3:0] hold the horizontal width and bits [7:4] hold the vertical width. A build-time parameter selects one of five controller variants (0 to 4). The variants differ in two ways: how a zero field is read (no pulse, or a full 16), and whether the vertical field is used at all. Each width is captured when its pulse starts. While a pulse is running, a new start strobe has no effect.

Top module: `sync_width_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `hsync` and `vsync` are low after that edge, and any pulse in progress is abandoned.
- R2: When `hs_start` is high at an edge while `hsync` is low and the decoded horizontal width N (from `sync_reg[3:0]`) is nonzero, `hsync` rises after that edge. It stays high for exactly N `char_tick` cycles and falls after the edge that samples the N-th tick. A tick in the start cycle itself is not counted.
- R3: On variants 0 and 1, `sync_reg[3:0]` = 0 produces no horizontal pulse.
- R4: On variants 2, 3 and 4, `sync_reg[3:0]` = 0 produces a horizontal pulse 16 ticks long.
- R5: On variants 0, 3 and 4, `sync_reg[7:4]` sets the vertical pulse length in `line_tick` cycles, with the same timing as R2. A value of 0 gives 16 lines.
- R6: On variants 1 and 2, `sync_reg[7:4]` is ignored and every vertical pulse lasts 16 lines.
- R7: The width is captured in the start cycle. Changing `sync_reg` during a pulse does not change that pulse's length.
- R8: A start strobe that arrives while its pulse is high is ignored. This includes a strobe in the same cycle as the final tick, after which the output goes low and stays low.
- R9: `line_tick` does not advance the horizontal pulse, and `char_tick` does not advance the vertical pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| char_tick | input | 1 | Character-clock enable; advances the horizontal pulse |
| line_tick | input | 1 | Raster-line enable; advances the vertical pulse |
| hs_start | input | 1 | Strobe: begin a horizontal sync pulse |
| vs_start | input | 1 | Strobe: begin a vertical sync pulse |
| sync_reg | input | 8 | Packed widths: [3:0] horizontal, [7:4] vertical |
| hsync | output | 1 | Horizontal sync output |
| vsync | output | 1 | Vertical sync output |

## Verification
Two functions of a pulse timer can fall in the same cycle: ending the running pulse on its final tick, and accepting a fresh start strobe. The bench provokes this by raising the start strobe together with the last `char_tick` of a 3-wide pulse. It judges the result by counting the ticks seen with the output high, which must be exactly 3, and by checking that the output stays low afterward instead of restarting. A second case raises a start strobe in the middle of a pulse, and the pulse length must not change.

// File: rtl/sync_gen_pkg.sv
package sync_gen_pkg;

    localparam int unsigned SYNC_FIELD_W = 4;

    // Variants 2..4 read a zero horizontal field as a full-length pulse.
    function automatic logic h_zero_is_full(input int unsigned variant);
        return variant >= 2;
    endfunction

    // Variants 1 and 2 ignore the vertical field and use a fixed length.
    function automatic logic v_is_fixed(input int unsigned variant);
        return (variant == 1) || (variant == 2);
    endfunction

endpackage

// File: rtl/sync_width_dec.sv
module sync_width_dec #(
    parameter int unsigned FIELD_W   = 4,
    parameter bit          ZERO_FULL = 1'b0,
    parameter bit          FIXED     = 1'b0,
    localparam int unsigned CNT_W    = FIELD_W + 1
) (
    input  logic [FIELD_W-1:0] field_i,
    output logic [CNT_W-1:0]   width_o
);
    localparam int unsigned FULL = 1 << FIELD_W;

    generate
        if (FIXED) begin : g_fixed
            logic unused_field;
            assign unused_field = ^field_i;
            assign width_o      = CNT_W'(FULL);
        end else begin : g_field
            always_comb begin
                if (field_i == '0) begin
                    width_o = ZERO_FULL ? CNT_W'(FULL) : '0;
                end else begin
                    width_o = {1'b0, field_i};
                end
            end
        end
    endgenerate

endmodule

// File: rtl/sync_pulse_timer.sv
module sync_pulse_timer #(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] width_i,
    output logic             pulse_o
);
    localparam int unsigned MAX_CNT = 1 << (CNT_W - 1);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
    } timer_t;

    timer_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.active) begin
            if (tick_i) begin
                if (st_q.cnt == CNT_W'(1)) begin
                    st_d.active = 1'b0;
                    st_d.cnt    = '0;
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
        end else if (start_i && (width_i != '0)) begin
            st_d.active = 1'b1;
            st_d.cnt    = width_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_o = st_q.active;

    // R2: an accepted start loads the captured width and raises the pulse
    assert_start_loads_R2: assert property (@(posedge clk) disable iff (rst)
        (start_i && !pulse_o && width_i != '0) |=> (pulse_o && st_q.cnt == $past(width_i)));

    // R2: a running pulse always has between 1 and the maximum ticks left
    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
        pulse_o |-> (st_q.cnt != '0 && st_q.cnt <= CNT_W'(MAX_CNT)));

    // R9: without its own tick the pulse neither ends nor advances
    assert_hold_no_tick_R9: assert property (@(posedge clk) disable iff (rst)
        (pulse_o && !tick_i) |=> (pulse_o && $stable(st_q.cnt)));

    // R8: a strobe on the final tick does not restart the pulse
    assert_last_tick_restart_R8: assert property (@(posedge clk) disable iff (rst)
        (pulse_o && tick_i && st_q.cnt == CNT_W'(1) && start_i) |=> !pulse_o);

endmodule

// File: rtl/sync_width_gen.sv
module sync_width_gen #(
    parameter int unsigned VARIANT = 0,
    parameter int unsigned FIELD_W = sync_gen_pkg::SYNC_FIELD_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               char_tick,
    input  logic               line_tick,
    input  logic               hs_start,
    input  logic               vs_start,
    input  logic [2*FIELD_W-1:0] sync_reg,
    output logic               hsync,
    output logic               vsync
);
    import sync_gen_pkg::*;

    localparam int unsigned CNT_W    = FIELD_W + 1;
    localparam bit          H_ZFULL  = h_zero_is_full(VARIANT);
    localparam bit          V_FIXED  = v_is_fixed(VARIANT);

    logic [CNT_W-1:0] h_width, v_width;

    sync_width_dec #(.FIELD_W(FIELD_W), .ZERO_FULL(H_ZFULL), .FIXED(1'b0)) u_hdec (
        .field_i (sync_reg[FIELD_W-1:0]),
        .width_o (h_width)
    );

    sync_width_dec #(.FIELD_W(FIELD_W), .ZERO_FULL(1'b1), .FIXED(V_FIXED)) u_vdec (
        .field_i (sync_reg[2*FIELD_W-1:FIELD_W]),
        .width_o (v_width)
    );

    sync_pulse_timer #(.CNT_W(CNT_W)) u_htmr (
        .clk     (clk),
        .rst     (rst),
        .start_i (hs_start),
        .tick_i  (char_tick),
        .width_i (h_width),
        .pulse_o (hsync)
    );

    sync_pulse_timer #(.CNT_W(CNT_W)) u_vtmr (
        .clk     (clk),
        .rst     (rst),
        .start_i (vs_start),
        .tick_i  (line_tick),
        .width_i (v_width),
        .pulse_o (vsync)
    );

    // R1: reset clears both outputs
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!hsync && !vsync));

    generate
        if (!H_ZFULL) begin : g_hzero_chk
            // R3: zero horizontal field never starts a pulse
            assert_hzero_none_R3: assert property (@(posedge clk) disable iff (rst)
                (hs_start && !hsync && sync_reg[FIELD_W-1:0] == '0) |=> !hsync);
        end else begin : g_hzero_full_chk
            // R4: zero horizontal field starts a pulse
            assert_hzero_full_R4: assert property (@(posedge clk) disable iff (rst)
                (hs_start && !hsync && sync_reg[FIELD_W-1:0] == '0) |=> hsync);
        end
    endgenerate

endmodule

// File: tb/sync_width_gen_tb.sv
module sync_width_gen_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       char_tick = 1'b0, line_tick = 1'b0;
    logic       hs_start = 1'b0, vs_start = 1'b0;
    logic [7:0] sync_reg = 8'h00;
    logic [4:0] hs, vs;

    int checks = 0;
    int errors = 0;
    int cnt [5];
    bit done = 1'b0;

    always #10 clk = ~clk;

    sync_width_gen #(.VARIANT(0)) u_dut (
        .clk(clk), .rst(rst), .char_tick(char_tick), .line_tick(line_tick),
        .hs_start(hs_start), .vs_start(vs_start), .sync_reg(sync_reg),
        .hsync(hs[0]), .vsync(vs[0])
    );

    for (genvar g = 1; g < 5; g++) begin : g_var
        sync_width_gen #(.VARIANT(g)) u_var (
            .clk(clk), .rst(rst), .char_tick(char_tick), .line_tick(line_tick),
            .hs_start(hs_start), .vs_start(vs_start), .sync_reg(sync_reg),
            .hsync(hs[g]), .vsync(vs[g])
        );
    end

    // Row: register, horizontal widths v0..v4, vertical widths v0..v4.
    localparam logic [57:0] VEC [4] = '{
        {8'h35, 5'd5,  5'd5,  5'd5,  5'd5,  5'd5,  5'd3,  5'd16, 5'd16, 5'd3,  5'd3},
        {8'h00, 5'd0,  5'd0,  5'd16, 5'd16, 5'd16, 5'd16, 5'd16, 5'd16, 5'd16, 5'd16},
        {8'hF1, 5'd1,  5'd1,  5'd1,  5'd1,  5'd1,  5'd15, 5'd16, 5'd16, 5'd15, 5'd15},
        {8'h8F, 5'd15, 5'd15, 5'd15, 5'd15, 5'd15, 5'd8,  5'd16, 5'd16, 5'd8,  5'd8}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Start one pulse and count the ticks delivered while it is high.
    task automatic measure(input bit horiz, input logic [7:0] mid_reg,
                           input int change_at, input int restart_at);
        for (int v = 0; v < 5; v++) cnt[v] = 0;
        @(negedge clk);
        if (horiz) hs_start = 1'b1; else vs_start = 1'b1;
        @(negedge clk);
        hs_start = 1'b0;
        vs_start = 1'b0;
        for (int k = 0; k < 40; k++) begin
            for (int v = 0; v < 5; v++)
                if (horiz ? hs[v] : vs[v]) cnt[v]++;
            if (k == change_at) sync_reg = mid_reg;
            if (k == restart_at) begin
                if (horiz) hs_start = 1'b1; else vs_start = 1'b1;
            end
            if (horiz) char_tick = 1'b1; else line_tick = 1'b1;
            @(negedge clk);
            char_tick = 1'b0;
            line_tick = 1'b0;
            hs_start  = 1'b0;
            vs_start  = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        for (int v = 0; v < 5; v++) begin
            check(hs[v] == 1'b0, "R1 reset hsync", hs[v], 0);
            check(vs[v] == 1'b0, "R1 reset vsync", vs[v], 0);
        end
        rst = 1'b0;

        // Table walk: R2 R3 R4 R5 R6
        for (int i = 0; i < 4; i++) begin
            sync_reg = VEC[i][57:50];
            measure(1'b1, 8'h00, -1, -1);
            for (int v = 0; v < 5; v++)
                check(cnt[v] == int'(VEC[i][49-5*v -: 5]), "R2/R3/R4 hsync width",
                      cnt[v], int'(VEC[i][49-5*v -: 5]));
            measure(1'b0, 8'h00, -1, -1);
            for (int v = 0; v < 5; v++)
                check(cnt[v] == int'(VEC[i][24-5*v -: 5]), "R5/R6 vsync width",
                      cnt[v], int'(VEC[i][24-5*v -: 5]));
        end

        // R7: register change mid-pulse affects only the next pulse
        sync_reg = 8'h24;
        measure(1'b1, 8'h69, 1, -1);
        for (int v = 0; v < 5; v++) check(cnt[v] == 4, "R7 hsync kept width", cnt[v], 4);
        measure(1'b1, 8'h00, -1, -1);
        for (int v = 0; v < 5; v++) check(cnt[v] == 9, "R7 hsync next width", cnt[v], 9);
        sync_reg = 8'h24;
        measure(1'b0, 8'h69, 0, -1);
        check(cnt[0] == 2, "R7 vsync kept width", cnt[0], 2);

        // R8: restart mid-pulse, and restart on the final tick
        sync_reg = 8'h33;
        measure(1'b1, 8'h00, -1, 1);
        for (int v = 0; v < 5; v++) check(cnt[v] == 3, "R8 mid restart ignored", cnt[v], 3);
        measure(1'b1, 8'h00, -1, 2);
        for (int v = 0; v < 5; v++) begin
            check(cnt[v] == 3, "R8 final-tick restart width", cnt[v], 3);
            check(hs[v] == 1'b0, "R8 final-tick no restart", hs[v], 0);
        end

        // R9: ticks of the other axis do not advance a pulse
        sync_reg = 8'h55;
        @(negedge clk); hs_start = 1'b1;
        @(negedge clk); hs_start = 1'b0;
        repeat (6) begin
            line_tick = 1'b1; @(negedge clk);
            line_tick = 1'b0; @(negedge clk);
        end
        check(hs[0] == 1'b1, "R9 hsync held under line ticks", hs[0], 1);
        repeat (5) begin
            char_tick = 1'b1; @(negedge clk);
            char_tick = 1'b0; @(negedge clk);
        end
        check(hs[0] == 1'b0, "R9 hsync ends on char ticks", hs[0], 0);
        @(negedge clk); vs_start = 1'b1;
        @(negedge clk); vs_start = 1'b0;
        repeat (6) begin
            char_tick = 1'b1; @(negedge clk);
            char_tick = 1'b0; @(negedge clk);
        end
        check(vs[0] == 1'b1, "R9 vsync held under char ticks", vs[0], 1);

        // R1: reset in the middle of pulses
        @(negedge clk); hs_start = 1'b1;
        @(negedge clk); hs_start = 1'b0; rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check(hs[0] == 1'b0, "R1 mid-pulse reset hsync", hs[0], 0);
        check(vs[0] == 1'b0, "R1 mid-pulse reset vsync", vs[0], 0);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule